// File: doc/BRIEF.md
# Frame Pulse Period Checker

The block watches a system-side frame-start pulse and measures it against the bit clock. It establishes a frame grid, then checks that each later pulse falls on that grid. A pulse may come every frame or only every few frames. Only a pulse that lands between grid points is treated as a fault.

A fault sets a sticky status flag. Software clears the flag with a write-one-to-clear strobe. An interrupt follows the flag while the interrupt enable is set. After a fault the grid is rebuilt around the offending pulse. The frame length in bit clocks is a parameter: 256 for a 2.048 Mbit/s port, 1024 for an 8.192 Mbit/s multiplexed port. A double-rate input doubles that length, and the pulse is then looked at only on the first clock edge of each bit period. A polarity input inverts the pulse before detection.

A two-state controller drives the block. In state HUNT it waits for the first pulse; the transition HUNT→LOCKED (first pulse) fixes the grid. In state LOCKED, three transitions exist:
- LOCKED→LOCKED (on-grid pulse) changes nothing.
- LOCKED→LOCKED (off-grid pulse) raises the flag and realigns the grid.
- Reset returns the controller to HUNT.

Top module: `frame_pulse_checker`

## Requirements
- R1: After reset, `status` and `irq` are 0, and the controller is hunting for its first pulse.
- R2: Pulses spaced exactly one frame apart do not set `status`. One frame is FRAME_BITS clocks at single rate and 2*FRAME_BITS clocks at double rate.
- R3: Pulses spaced at any whole multiple of the frame length, two frames or more, do not set `status`.
- R4: A pulse whose spacing from the previous pulse is not a whole multiple of the frame length sets `status`. The flag is visible one clock after the clock edge at which the pulse is sampled.
- R5: `status` stays 1 until a clock with `status_clr`=1 clears it. If an off-grid pulse arrives in the same clock as the clear, the flag stays set.
- R6: `irq` equals `status` AND `irq_en` at all times.
- R7: With `fp_invert`=1, a low level on `fp_raw` is the active pulse level. With `fp_invert`=0, a high level is active.
- R8: The first pulse after reset never sets `status`; it fixes the frame grid.
- R9: After an off-grid pulse, the grid realigns to that pulse. A following pulse one frame later counts as on-grid.
- R10: With `double_rate`=1, only clocks 0, 2, 4, … after reset release sample the pulse. A pulse active only on an odd clock is ignored.
- R11: A pulse is its inactive-to-active transition, as seen at sampling clocks. A pulse held active for several clocks counts once, and its spacing is measured from its leading edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock (doubled when double_rate=1) |
| rst_n | input | 1 | Active-low asynchronous reset |
| fp_raw | input | 1 | Frame pulse as received |
| fp_invert | input | 1 | 1: pulse is active low |
| double_rate | input | 1 | 1: clock runs at twice the bit rate |
| irq_en | input | 1 | Interrupt enable for the status flag |
| status_clr | input | 1 | Write-one-to-clear strobe for the flag |
| status | output | 1 | Sticky off-grid pulse flag |
| irq | output | 1 | Interrupt request |

## Verification
Directed patterns exercise several pulse schedules:
- Pulses every frame and every few frames must leave the flag clear.
- Spacings one clock off the grid must set the flag.
- Wide pulses separate leading-edge detection from level detection.
- A pulse confined to an odd clock in double-rate mode separates sampling on the first edge from sampling on both edges.
- A clear that coincides with an off-grid pulse shows the set winning.

Random schedules then mix on-grid multiples, off-grid offsets, random widths, clears and enable changes. This is done for each polarity and clock rate, and every result is compared against a spacing model in the bench.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic [0:0] {
        FPC_HUNT   = 1'b0,
        FPC_LOCKED = 1'b1
    } fpc_state_e;
endpackage

// File: rtl/fpc_pulse_qual.sv
module fpc_pulse_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic fp_raw,
    input  logic fp_invert,
    input  logic double_rate,
    output logic eval_en,
    output logic pulse_evt
);
    logic phase_q;
    logic prev_q;
    logic act;

    assign act     = fp_raw ^ fp_invert;
    assign eval_en = !double_rate || !phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            prev_q  <= 1'b1;
        end else begin
            phase_q <= !phase_q;
            if (eval_en) begin
                prev_q <= act;
            end
        end
    end

    assign pulse_evt = eval_en && act && !prev_q;

    AST_EVAL_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (double_rate && $past(double_rate) && eval_en) |=> !eval_en); // R10
endmodule

// File: rtl/fpc_frame_count.sv
module fpc_frame_count #(
    parameter int FRAME_BITS = 256
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                double_rate,
    input  logic                                run,
    input  logic                                load,
    output logic [$clog2(2*FRAME_BITS)-1:0]     cnt,
    output logic                                at_zero
);
    localparam int CW = $clog2(2*FRAME_BITS);
    localparam logic [CW-1:0] LAST_SR = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] LAST_DR = CW'(2*FRAME_BITS - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_val;

    assign last_val = double_rate ? LAST_DR : LAST_SR;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(1);
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q >= last_val) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign cnt     = cnt_q;
    assign at_zero = (cnt_q == '0);

    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !double_rate && $past(!double_rate)) |-> (cnt_q <= LAST_SR)); // R2
    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == CW'(1))); // R9
endmodule

// File: rtl/fpc_sticky_status.sv
module fpc_sticky_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q); // R5
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q); // R4
endmodule

// File: rtl/frame_pulse_checker.sv
module frame_pulse_checker
    import fpc_pkg::*;
#(
    parameter int FRAME_BITS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fp_raw,
    input  logic fp_invert,
    input  logic double_rate,
    input  logic irq_en,
    input  logic status_clr,
    output logic status,
    output logic irq
);
    localparam int CW = $clog2(2*FRAME_BITS);

    fpc_state_e    state_q, state_d;
    logic          eval_en;
    logic          pulse_evt;
    logic          at_zero;
    logic          good_evt;
    logic          bad_evt;
    logic          status_int;
    logic [CW-1:0] cnt;

    fpc_pulse_qual u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .fp_raw      (fp_raw),
        .fp_invert   (fp_invert),
        .double_rate (double_rate),
        .eval_en     (eval_en),
        .pulse_evt   (pulse_evt)
    );

    fpc_frame_count #(.FRAME_BITS(FRAME_BITS)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .double_rate (double_rate),
        .run         (state_q == FPC_LOCKED),
        .load        (pulse_evt),
        .cnt         (cnt),
        .at_zero     (at_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FPC_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and pulse classification
    always_comb begin
        state_d  = state_q;
        good_evt = 1'b0;
        bad_evt  = 1'b0;
        unique case (state_q)
            FPC_HUNT: begin
                if (pulse_evt) begin
                    state_d = FPC_LOCKED;
                end
            end
            FPC_LOCKED: begin
                if (pulse_evt) begin
                    if (at_zero) begin
                        good_evt = 1'b1;
                    end else begin
                        bad_evt = 1'b1;
                    end
                end
            end
            default: state_d = FPC_HUNT;
        endcase
    end

    fpc_sticky_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (bad_evt),
        .clr_req (status_clr),
        .flag    (status_int)
    );

    // Outputs
    always_comb begin
        status = status_int;
        irq    = status_int && irq_en;
    end

    AST_HUNT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FPC_HUNT) |-> !bad_evt); // R8
    AST_GOOD_NOT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        good_evt |-> !bad_evt); // R2
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status); // R6
    AST_LOCK_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_evt |=> (state_q == FPC_LOCKED)); // R9
endmodule

// File: tb/frame_pulse_checker_tb.sv
module frame_pulse_checker_tb_top;
    localparam int FB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fp_raw = 1'b0;
    logic fp_invert = 1'b0;
    logic double_rate = 1'b0;
    logic irq_en = 1'b0;
    logic status_clr = 1'b0;
    logic status, irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // model state
    int  m_n;
    bit  m_aligned;
    int  m_last;
    bit  m_prev;
    bit  m_st;
    bit  cfg_inv;
    bit  cfg_dr;
    int  prev_w;

    always #10 clk = ~clk;

    frame_pulse_checker #(.FRAME_BITS(FB)) dut_i (
        .clk(clk), .rst_n(rst_n), .fp_raw(fp_raw), .fp_invert(fp_invert),
        .double_rate(double_rate), .irq_en(irq_en), .status_clr(status_clr),
        .status(status), .irq(irq)
    );

    function automatic int frame_len(bit dr);
        return dr ? 2*FB : FB;
    endfunction

    function automatic bit is_eval_clock(bit dr, int n);
        return !dr || (n % 2 == 0);
    endfunction

    function automatic bit off_grid(int n, int last, bit dr);
        return ((n - last) % frame_len(dr)) != 0;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at model clock %0d", tag, act, exp, m_n);
        end
    endtask

    task automatic reset_dut(bit dr, bit inv, bit en);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_dr = dr; cfg_inv = inv;
        double_rate = dr; fp_invert = inv; irq_en = en;
        fp_raw = inv; status_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_n = 0; m_aligned = 0; m_last = 0; m_prev = 1; m_st = 0; prev_w = 1;
        check("R1 status after reset", status, 1'b0);
        check("R1 irq after reset", irq, 1'b0);
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(bit a, bit clr, string tag);
        bit setb;
        fp_raw = a ^ cfg_inv;
        status_clr = clr;
        @(posedge clk);
        setb = 0;
        if (is_eval_clock(cfg_dr, m_n)) begin
            if (a && !m_prev) begin
                if (!m_aligned) begin
                    m_aligned = 1;
                end else if (off_grid(m_n, m_last, cfg_dr)) begin
                    setb = 1;
                end
                m_last = m_n;
            end
            m_prev = a;
        end
        if (setb) m_st = 1;
        else if (clr) m_st = 0;
        m_n++;
        @(negedge clk);
        check(tag, status, m_st);
        check({tag, " (R6 irq)"}, irq, m_st & irq_en);
    endtask

    // Leading edge 'spacing' clocks after previous leading edge, width w
    task automatic pulse_sp(int spacing, int w, string tag);
        for (int i = 0; i < spacing - prev_w; i++) cyc(1'b0, 1'b0, tag);
        for (int i = 0; i < w; i++) cyc(1'b1, 1'b0, tag);
        prev_w = w;
    endtask

    task automatic clear_flag(string tag);
        cyc(1'b0, 1'b1, tag);
        prev_w++;
    endtask

    task automatic random_run(int iters, bit dr);
        int L = frame_len(dr);
        for (int it = 0; it < iters; it++) begin
            int k = 1 + int'($urandom_range(0, 2));
            int off = ($urandom_range(0, 9) < 6) ? 0 : int'($urandom_range(1, L - 1));
            int w = dr ? int'($urandom_range(2, 4)) : int'($urandom_range(1, 3));
            if ($urandom_range(0, 3) == 0) irq_en = ~irq_en;
            if ($urandom_range(0, 4) == 0) clear_flag("R5 random clear");
            pulse_sp(k*L + off, w, "R2/R3/R4 random");
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        // Single rate, active high
        reset_dut(1'b0, 1'b0, 1'b1);
        pulse_sp(5, 1, "R8 first pulse");
        pulse_sp(FB, 1, "R2 one frame");
        pulse_sp(FB, 1, "R2 one frame");
        pulse_sp(3*FB, 1, "R3 three frames");
        pulse_sp(2*FB, 3, "R11 wide pulse");
        pulse_sp(FB, 2, "R11 wide pulse");
        pulse_sp(FB + 1, 1, "R4 one late");
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, "R5 sticky");
        prev_w += 10;
        clear_flag("R5 clear");
        pulse_sp(FB, 1, "R9 realigned");
        pulse_sp(2*FB, 1, "R9 realigned");
        pulse_sp(FB - 1, 1, "R4 one early");
        clear_flag("R5 clear");
        for (int i = 0; i < FB - 2; i++) cyc(1'b0, 1'b0, "R5 wait");
        cyc(1'b0, 1'b1, "R5 clear");
        cyc(1'b1, 1'b1, "R5 set beats clear");
        prev_w = 1;
        irq_en = 1'b0;
        pulse_sp(FB + 4, 1, "R6 masked");
        irq_en = 1'b1;
        cyc(1'b0, 1'b0, "R6 unmasked");
        prev_w++;
        random_run(60, 1'b0);

        // Single rate, active low
        reset_dut(1'b0, 1'b1, 1'b1);
        pulse_sp(3, 1, "R7 R8 inverted first");
        pulse_sp(FB, 1, "R7 inverted on grid");
        pulse_sp(2*FB, 2, "R7 inverted on grid");
        pulse_sp(FB + 2, 1, "R7 inverted off grid");
        random_run(60, 1'b0);

        // Double rate
        reset_dut(1'b1, 1'b0, 1'b1);
        pulse_sp(4, 2, "R10 first");
        pulse_sp(2*FB, 2, "R10 doubled frame");
        pulse_sp(4*FB, 2, "R10 two doubled frames");
        // pulse only on an odd clock: ignored
        pulse_sp(2*FB + 1, 1, "R10 odd clock ignored");
        pulse_sp(2*FB - 1, 2, "R10 on grid after ignored");
        pulse_sp(FB, 2, "R10 single-rate spacing is off grid");
        random_run(60, 1'b1);

        // Double rate inverted
        reset_dut(1'b1, 1'b1, 1'b0);
        random_run(40, 1'b1);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule